// File: doc/BRIEF.md
# Garage Door Sequencer

This block sequences a motorised garage door from one shared command. A rising edge on either the wall button or the remote button counts as a single command. The door can be in one of six states: closed, opening, open, closing, halted while rising, or halted while falling. A command given while the door is at rest starts it moving. A command given while it moves halts it. The next command sends it the other way. The top and bottom limit switches end travel. An interrupted infrared beam during closing sends the door back up.

A lamp timer lights the garage after every completed travel. It counts ticks of an external one-second enable and reloads whenever another travel completes. After reset the door state is taken from the limit switches. All inputs are plain level signals sampled on the clock. No stream data crosses the block, so it has no valid/ready interface.

Top module: `garage_door_ctrl`

## Requirements
- R1: A command is a cycle in which `btn_wall` or `btn_remote` is 1 after being 0 in the previous sampled cycle. A button held high for many cycles gives exactly one command. Both buttons have the same effect.
- R2: A command while closed starts opening. A command while open starts closing.
- R3: A command while opening (top switch open) halts the door in halted-rising. A command while closing (bottom switch open, beam intact) halts it in halted-falling. A command in halted-rising starts closing. A command in halted-falling starts opening.
- R4: While opening, `lim_top`=1 moves the door to open. While closing, `lim_bot`=1 moves it to closed. In both cases the limit switch wins over a command or beam event in the same cycle.
- R5: While closing with `lim_bot`=0, `beam_cut`=1 moves the door to opening, and this wins over a command. `beam_cut` has no effect in any other state.
- R6: `motor_up` is 1 exactly while opening and `motor_dn` is 1 exactly while closing. The two are never 1 together. Outputs change in the cycle after the clock edge that samples the cause.
- R7: A completed travel sets the lamp timer to LIGHT_TICKS. Each `tick_1s` pulse while it is nonzero counts it down. `light_on` is 1 while the count is nonzero. A completion while the lamp is lit reloads the full count.
- R8: While `rst_n`=0, the state becomes closed if `lim_bot`=1, otherwise open if `lim_top`=1, otherwise halted-falling. The lamp is off and both motors are off after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_wall | input | 1 | Wall push button level |
| btn_remote | input | 1 | Remote push button level |
| lim_top | input | 1 | Top limit switch made |
| lim_bot | input | 1 | Bottom limit switch made |
| beam_cut | input | 1 | Infrared beam interrupted |
| tick_1s | input | 1 | One-cycle pulse per second |
| motor_up | output | 1 | Drive door upward |
| motor_dn | output | 1 | Drive door downward |
| light_on | output | 1 | Garage lamp |

## Verification
The bench builds the block with LIGHT_TICKS set to 5 instead of 300. At that value, a full lamp countdown, its expiry and a reload in the middle of a countdown all fit in a few dozen cycles. Ticks are pulsed at a chosen rate, so the lamp can be seen both lit and dark around each completion. All three reset outcomes are reached by pulsing reset with different switch settings.

// File: rtl/gdc_pkg.sv
package gdc_pkg;
  typedef enum logic [2:0] {
    DOOR_SHUT    = 3'd0,
    DOOR_RISING  = 3'd1,
    DOOR_UP      = 3'd2,
    DOOR_FALLING = 3'd3,
    HALT_RISE    = 3'd4,
    HALT_FALL    = 3'd5
  } door_st_e;
endpackage

// File: rtl/gdc_cmd_edge.sv
module gdc_cmd_edge #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] btn,
  output logic             press
);
  logic [N_SRC-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= btn;
  end

  // any source rising counts as one shared command
  assign press = |(btn & ~prev_q);
endmodule

// File: rtl/gdc_fsm.sv
module gdc_fsm
  import gdc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     press,
  input  logic     lim_top,
  input  logic     lim_bot,
  input  logic     beam_cut,
  output door_st_e state_o,
  output logic     done
);
  door_st_e state_q, state_d, init_st;

  always_comb begin
    if (lim_bot)      init_st = DOOR_SHUT;
    else if (lim_top) init_st = DOOR_UP;
    else              init_st = HALT_FALL;
  end

  always_comb begin
    state_d = state_q;
    done    = 1'b0;
    unique case (state_q)
      DOOR_SHUT:    if (press) state_d = DOOR_RISING;
      DOOR_UP:      if (press) state_d = DOOR_FALLING;
      HALT_RISE:    if (press) state_d = DOOR_FALLING;
      HALT_FALL:    if (press) state_d = DOOR_RISING;
      DOOR_RISING: begin
        if (lim_top) begin
          state_d = DOOR_UP;
          done    = 1'b1;
        end else if (press) state_d = HALT_RISE;
      end
      DOOR_FALLING: begin
        if (lim_bot) begin
          state_d = DOOR_SHUT;
          done    = 1'b1;
        end else if (beam_cut) state_d = DOOR_RISING;
        else if (press)        state_d = HALT_FALL;
      end
      default: state_d = HALT_FALL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= init_st;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  assert_top_ends_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DOOR_RISING && lim_top) |=> state_q == DOOR_UP);
  assert_bot_ends_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DOOR_FALLING && lim_bot) |=> state_q == DOOR_SHUT);
  assert_beam_reverses_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DOOR_FALLING && !lim_bot && beam_cut) |=> state_q == DOOR_RISING);
  assert_press_halts_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DOOR_RISING && !lim_top && press) |=> state_q == HALT_RISE);
endmodule

// File: rtl/gdc_lamp_timer.sv
module gdc_lamp_timer #(
  parameter int TICKS = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic tick,
  output logic lamp
);
  localparam int CW = $clog2(TICKS + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (done)                  cnt_q <= CW'(TICKS);
    else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign lamp = (cnt_q != '0);

  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cnt_q == CW'(TICKS));
  assert_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/garage_door_ctrl.sv
module garage_door_ctrl
  import gdc_pkg::*;
#(
  parameter int LIGHT_TICKS = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_wall,
  input  logic btn_remote,
  input  logic lim_top,
  input  logic lim_bot,
  input  logic beam_cut,
  input  logic tick_1s,
  output logic motor_up,
  output logic motor_dn,
  output logic light_on
);
  logic     press, done;
  door_st_e state;

  gdc_cmd_edge #(.N_SRC(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .btn({btn_remote, btn_wall}), .press(press)
  );

  gdc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .press(press), .lim_top(lim_top),
    .lim_bot(lim_bot), .beam_cut(beam_cut), .state_o(state), .done(done)
  );

  gdc_lamp_timer #(.TICKS(LIGHT_TICKS)) u_lamp (
    .clk(clk), .rst_n(rst_n), .done(done), .tick(tick_1s), .lamp(light_on)
  );

  assign motor_up = (state == DOOR_RISING);
  assign motor_dn = (state == DOOR_FALLING);

  assert_lamp_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> light_on);
endmodule

// File: tb/garage_door_ctrl_bench.sv
module garage_door_ctrl_bench;
  localparam int LT = 5;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_wall = 0, btn_remote = 0, lim_top = 0, lim_bot = 0, beam_cut = 0, tick_1s = 0;
  logic motor_up, motor_dn, light_on;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R8";
  bit running = 1'b0;

  // reference: 0 shut,1 rising,2 up,3 falling,4 halt-rise,5 halt-fall
  int m_st = 0, m_cnt = 0;
  bit pw = 0, pr = 0;

  always #4 clk = ~clk;

  garage_door_ctrl #(.LIGHT_TICKS(LT)) u_garage_door_ctrl (
    .clk(clk), .rst_n(rst_n), .btn_wall(btn_wall), .btn_remote(btn_remote),
    .lim_top(lim_top), .lim_bot(lim_bot), .beam_cut(beam_cut), .tick_1s(tick_1s),
    .motor_up(motor_up), .motor_dn(motor_dn), .light_on(light_on)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = lim_bot ? 0 : (lim_top ? 2 : 5);
      m_cnt = 0; pw = 0; pr = 0;
    end else begin
      bit cmd, fin;
      cmd = (btn_wall && !pw) || (btn_remote && !pr);
      pw = btn_wall; pr = btn_remote;
      fin = 0;
      case (m_st)
        0: if (cmd) m_st = 1;
        2: if (cmd) m_st = 3;
        4: if (cmd) m_st = 3;
        5: if (cmd) m_st = 1;
        1: if (lim_top) begin m_st = 2; fin = 1; end else if (cmd) m_st = 4;
        3: if (lim_bot) begin m_st = 0; fin = 1; end
           else if (beam_cut) m_st = 1; else if (cmd) m_st = 5;
        default: m_st = 5;
      endcase
      if (fin) m_cnt = LT;
      else if (tick_1s && m_cnt != 0) m_cnt = m_cnt - 1;
    end
  end

  task automatic chk(input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (running) begin
    chk("motor_up", motor_up, m_st == 1);
    chk("motor_dn", motor_dn, m_st == 3);
    chk("light_on", light_on, m_cnt != 0);
    chk("R6 no double drive", motor_up & motor_dn, 1'b0);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic top, input logic bot);
    rst_n = 0; lim_top = top; lim_bot = bot;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  initial begin
    #(8 * 5000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    lim_bot = 1;
    step(2);
    running = 1;
    cur_req = "R8";
    do_reset(0, 1);
    chk("R8 reset shut light", light_on, 1'b0);
    cur_req = "R1";
    btn_wall = 1; step(1); lim_bot = 0; step(4);
    chk("R1 held gives one command", motor_up, 1'b1);
    btn_wall = 0; step(1);
    cur_req = "R3";
    btn_remote = 1; step(1); btn_remote = 0; step(1);
    chk("R3 halt rise", motor_up, 1'b0);
    btn_wall = 1; step(1); btn_wall = 0; step(1);
    chk("R3 reverse to fall", motor_dn, 1'b1);
    cur_req = "R5";
    beam_cut = 1; step(1); step(1);
    chk("R5 beam reverses", motor_up, 1'b1);
    step(2); beam_cut = 0;
    chk("R5 beam ignored while rising", motor_up, 1'b1);
    cur_req = "R4";
    lim_top = 1; btn_remote = 1; step(1); btn_remote = 0; step(1);
    chk("R4 top wins over press", light_on, 1'b1);
    cur_req = "R7";
    tick_1s = 1; step(2); tick_1s = 0; step(1);
    cur_req = "R2";
    btn_wall = 1; step(1); btn_wall = 0; lim_top = 0; step(1);
    chk("R2 up to falling", motor_dn, 1'b1);
    cur_req = "R3";
    btn_remote = 1; step(1); btn_remote = 0; step(1);
    btn_remote = 1; step(1); btn_remote = 0; step(2);
    chk("R3 halt-fall to rise", motor_up, 1'b1);
    cur_req = "R7";
    lim_top = 1; step(2);
    chk("R7 reload mid countdown", light_on, 1'b1);
    btn_wall = 1; step(1); btn_wall = 0; lim_top = 0; step(3);
    cur_req = "R4";
    lim_bot = 1; beam_cut = 1; step(1); beam_cut = 0; step(1);
    chk("R4 bottom wins over beam", motor_up, 1'b0);
    cur_req = "R7";
    for (int i = 0; i < 8; i++) begin tick_1s = 1; step(1); tick_1s = 0; step(1); end
    chk("R7 lamp expired", light_on, 1'b0);
    cur_req = "R5";
    beam_cut = 1; step(2); beam_cut = 0;
    chk("R5 beam ignored when shut", motor_up, 1'b0);
    cur_req = "R8";
    do_reset(1, 0);
    btn_wall = 1; step(1); btn_wall = 0; step(1);
    chk("R8 reset up then press falls", motor_dn, 1'b1);
    do_reset(0, 0);
    chk("R8 reset mid no motor", motor_up | motor_dn, 1'b0);
    btn_remote = 1; step(1); btn_remote = 0; step(1);
    chk("R8 halt-fall then press rises", motor_up, 1'b1);
    step(2);
    running = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule